// File: doc/BRIEF.md
# Doorbell and Message-Register Mailbox

This block is one direction of an inter-processor mailbox. A sending processor fills a 32-entry array of 32-bit message words, then rings a doorbell by writing a trigger register. The receiving processor takes an interrupt, reads the words it needs, and answers through the same trigger register with an acknowledge. That acknowledge raises an interrupt on the sending side. Both processors reach the block over one shared 32-bit register bus. Reads return data one cycle after the read strobe.

The two events live in one status register. Each side has its own enable register, and each interrupt line is the OR of the status bits masked by that side's enables. Status bits are cleared by writing ones to a separate clear register. The first message word carries the message byte length in its low seven bits. The block decodes that length into a word count, so a receiver knows how many entries to fetch.

Top module: `mbx_doorbell_top`

## Requirements
- R1: After reset, all message words, both enable registers and the status register read zero, both interrupt lines are low, and the decoded word count is zero.
- R2: Message word i (0 to 31) is read and written at byte offset 4*i (0x00 to 0x7C). Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R3: A write to offset 0x80 sets status bit 0 (doorbell) when data bit 0 is 1, and status bit 1 (acknowledge) when data bit 1 is 1. The bit is set in the cycle after the write. Both bits may be set by one write. A write of zero changes nothing.
- R4: The status register reads at offset 0xC8, with the doorbell in bit 0, the acknowledge in bit 1, and zeros above.
- R5: A write to offset 0xC4 clears each status bit whose data bit is 1. Status bits written with 0 keep their value.
- R6: `irq_snd` is high exactly when some status bit is 1 and the same bit of the sender enable register (offset 0xBC) is 1. It stays high until that bit is cleared.
- R7: `irq_rcv` is high exactly when some status bit is 1 and the same bit of the receiver enable register (offset 0xC0) is 1. It stays high until that bit is cleared.
- R8: Writes to the message words never change the status register.
- R9: `msg_word_count` equals the low 7 bits of message word 0, rounded up to a multiple of 4 and divided by 4 (0 to 32). Bits 31:7 of word 0 have no effect on it.
- R10: Each enable register stores data bits 1:0 and reads them back at its own offset, with zeros above.
- R11: Reads of the trigger register, the clear register and any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_snd | output | 1 | Sender-side interrupt (level) |
| irq_rcv | output | 1 | Receiver-side interrupt (level) |
| msg_word_count | output | 6 | Word count decoded from message word 0 |

## Verification
On every cycle, the assertions check the following:
- the set behaviour of both trigger bits;
- that a write-one clear takes effect;
- that status holds when neither the trigger nor the clear register is written, which covers message-word writes;
- that each interrupt line stays high while its status and enables are untouched;
- that the read data holds between reads;
- that the word count stays in range.

Only the bench scenarios can show the rest:
- the actual register contents returned at each offset;
- the routing of each event to the correct side's enable;
- the rounding of the length decode at 0, 4, 5, 13 and 127 bytes;
- the zero reads of write-only and unmapped offsets.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int MSG_WORDS = 32;
    localparam int NUM_EV    = 2;
    localparam int LEN_W     = 7;

    localparam int EV_DOORBELL = 0;
    localparam int EV_ACK      = 1;

    localparam logic [ADDR_W-1:0] OFF_TRIGGER = 8'h80;
    localparam logic [ADDR_W-1:0] OFF_EN_SND  = 8'hBC;
    localparam logic [ADDR_W-1:0] OFF_EN_RCV  = 8'hC0;
    localparam logic [ADDR_W-1:0] OFF_CLEAR   = 8'hC4;
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 8'hC8;
endpackage

// File: rtl/mbx_msg_store.sv
module mbx_msg_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] word0
);
    logic [DATA_W-1:0] view [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DATA_W-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (we && widx == IDX_W'(g)) begin
                w_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) w_q <= '0;
            else        w_q <= w_d;
        end

        assign view[g] = w_q;
    end

    assign rword = view[ridx];
    assign word0 = view[0];
endmodule

// File: rtl/mbx_event_ctrl.sv
module mbx_event_ctrl
    import mbx_pkg::*;
#(
    parameter int NEV = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig_we,
    input  logic           clr_we,
    input  logic           en_snd_we,
    input  logic           en_rcv_we,
    input  logic [NEV-1:0] wbits,
    output logic [NEV-1:0] sts,
    output logic [NEV-1:0] en_snd,
    output logic [NEV-1:0] en_rcv,
    output logic           irq_snd,
    output logic           irq_rcv
);
    typedef struct packed {
        logic [NEV-1:0] sts;
        logic [NEV-1:0] en_snd;
        logic [NEV-1:0] en_rcv;
    } ev_state_t;

    ev_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we)    st_d.sts    = st_d.sts & ~wbits;
        if (trig_we)   st_d.sts    = st_d.sts | wbits;
        if (en_snd_we) st_d.en_snd = wbits;
        if (en_rcv_we) st_d.en_rcv = wbits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts     = st_q.sts;
    assign en_snd  = st_q.en_snd;
    assign en_rcv  = st_q.en_rcv;
    assign irq_snd = |(st_q.sts & st_q.en_snd);
    assign irq_rcv = |(st_q.sts & st_q.en_rcv);

    AST_DOORBELL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        trig_we && wbits[EV_DOORBELL] |=> sts[EV_DOORBELL]); // R3
    AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        trig_we && wbits[EV_ACK] |=> sts[EV_ACK]); // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && !trig_we && wbits[EV_DOORBELL] |=> !sts[EV_DOORBELL]); // R5
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_we && !clr_we |=> $stable(sts)); // R8
    AST_SND_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_snd && !clr_we && !en_snd_we |=> irq_snd); // R6
    AST_RCV_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rcv && !clr_we && !en_rcv_we |=> irq_rcv); // R7
endmodule

// File: rtl/mbx_len_decode.sv
module mbx_len_decode #(
    parameter int LEN_W = 7,
    localparam int CNT_W = $clog2((((1 << LEN_W) + 2) / 4) + 1)
) (
    input  logic [LEN_W-1:0] len_bytes,
    output logic [CNT_W-1:0] words
);
    logic [LEN_W:0] rounded;

    always_comb begin
        rounded = {1'b0, len_bytes} + (LEN_W+1)'(3);
        words   = CNT_W'(rounded >> 2);
    end
endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top
    import mbx_pkg::*;
#(
    parameter int MSG_DEPTH = MSG_WORDS,
    parameter int DW        = DATA_W,
    parameter int AW        = ADDR_W,
    parameter int LW        = LEN_W,
    localparam int IDX_W    = $clog2(MSG_DEPTH),
    localparam int CNT_W    = $clog2((((1 << LW) + 2) / 4) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_snd,
    output logic          irq_rcv,
    output logic [CNT_W-1:0] msg_word_count
);
    localparam logic [AW-1:0] MSG_SPAN = AW'(MSG_DEPTH * 4);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    logic              in_msg;
    logic [IDX_W-1:0]  word_idx;
    logic [DW-1:0]     msg_rword;
    logic [DW-1:0]     msg_word0;
    logic [NUM_EV-1:0] sts, en_snd, en_rcv;
    logic              trig_we, clr_we, en_snd_we, en_rcv_we;

    assign in_msg    = bus_addr < MSG_SPAN;
    assign word_idx  = bus_addr[IDX_W+1:2];
    assign trig_we   = bus_wr && bus_addr == OFF_TRIGGER;
    assign clr_we    = bus_wr && bus_addr == OFF_CLEAR;
    assign en_snd_we = bus_wr && bus_addr == OFF_EN_SND;
    assign en_rcv_we = bus_wr && bus_addr == OFF_EN_RCV;

    mbx_msg_store #(.DEPTH(MSG_DEPTH), .DATA_W(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && in_msg),
        .widx  (word_idx),
        .wdata (bus_wdata),
        .ridx  (word_idx),
        .rword (msg_rword),
        .word0 (msg_word0)
    );

    mbx_event_ctrl #(.NEV(NUM_EV)) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_we   (trig_we),
        .clr_we    (clr_we),
        .en_snd_we (en_snd_we),
        .en_rcv_we (en_rcv_we),
        .wbits     (bus_wdata[NUM_EV-1:0]),
        .sts       (sts),
        .en_snd    (en_snd),
        .en_rcv    (en_rcv),
        .irq_snd   (irq_snd),
        .irq_rcv   (irq_rcv)
    );

    mbx_len_decode #(.LEN_W(LW)) u_len (
        .len_bytes (msg_word0[LW-1:0]),
        .words     (msg_word_count)
    );

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            if (in_msg)                     rd_d.rdata = msg_rword;
            else if (bus_addr == OFF_STATUS) rd_d.rdata = DW'(sts);
            else if (bus_addr == OFF_EN_SND) rd_d.rdata = DW'(en_snd);
            else if (bus_addr == OFF_EN_RCV) rd_d.rdata = DW'(en_rcv);
            else                             rd_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R2
    AST_MSG_WR_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && in_msg |=> $stable(sts)); // R8
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_word_count <= CNT_W'(((1 << LW) + 2) / 4)); // R9
endmodule

// File: tb/mbx_doorbell_top_bench.sv
module mbx_doorbell_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_snd, irq_rcv;
    logic [5:0]  msg_word_count;

    int n_chk  = 0;
    int n_fail = 0;
    logic pend = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sbq[$];

    always #10 clk = ~clk;

    mbx_doorbell_top u_mbx_doorbell_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_snd(irq_snd), .irq_rcv(irq_rcv), .msg_word_count(msg_word_count)
    );

    always @(posedge clk) pend <= bus_rd && rst_n;

    always @(negedge clk) begin
        if (pend) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read with no expectation, actual %h expected none", bus_rdata);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hC3A50000 ^ (32'(i) * 32'h01010101);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(32'(irq_snd), 0, "R1 irq_snd after reset");
        chk(32'(irq_rcv), 0, "R1 irq_rcv after reset");
        chk(32'(msg_word_count), 0, "R1 word count after reset");
        rd(8'hC8, 0, "R1 status after reset");
        rd(8'hBC, 0, "R1 sender enable after reset");
        rd(8'hC0, 0, "R1 receiver enable after reset");
        rd(8'h00, 0, "R1 word 0 after reset");
        rd(8'h7C, 0, "R1 word 31 after reset");

        // R2 message storage
        for (int i = 0; i < 32; i++) wr(8'(i * 4), pat(i));
        for (int i = 0; i < 32; i += 5) rd(8'(i * 4), pat(i), "R2 message word readback");
        rd(8'h7C, pat(31), "R2 last message word");
        // R8 message writes left status untouched
        rd(8'hC8, 0, "R8 status after message writes");

        // R9 length decode
        wr(8'h00, 32'd13);        chk(32'(msg_word_count), 4, "R9 13 bytes");
        wr(8'h00, 32'd4);         chk(32'(msg_word_count), 1, "R9 4 bytes");
        wr(8'h00, 32'h0000007F);  chk(32'(msg_word_count), 32, "R9 127 bytes");
        wr(8'h00, 32'hFFFFFF05);  chk(32'(msg_word_count), 2, "R9 upper bits ignored");
        wr(8'h00, 32'h00000080);  chk(32'(msg_word_count), 0, "R9 bit 7 ignored");

        // R10 enables
        wr(8'hBC, 32'hFFFFFFFF);
        rd(8'hBC, 32'h3, "R10 sender enable two bits");
        wr(8'hC0, 32'hFFFFFFFE);
        rd(8'hC0, 32'h2, "R10 receiver enable two bits");
        wr(8'hBC, 32'h2);
        wr(8'hC0, 32'h1);

        // R3 zero trigger has no effect
        wr(8'h80, 32'h0);
        rd(8'hC8, 0, "R3 zero trigger status");
        chk(32'({irq_snd, irq_rcv}), 0, "R3 zero trigger irqs");

        // R3/R7 doorbell
        wr(8'h80, 32'h1);
        chk(32'(irq_rcv), 1, "R7 doorbell raises irq_rcv");
        chk(32'(irq_snd), 0, "R6 doorbell not on irq_snd");
        rd(8'hC8, 32'h1, "R3 doorbell status bit 0");
        repeat (4) @(negedge clk);
        chk(32'(irq_rcv), 1, "R7 irq_rcv level holds");
        wr(8'hC4, 32'h2);
        rd(8'hC8, 32'h1, "R5 clear of other bit keeps doorbell");
        wr(8'h10, 32'h12345678);
        rd(8'hC8, 32'h1, "R8 message write keeps doorbell");
        wr(8'hC4, 32'h1);
        chk(32'(irq_rcv), 0, "R5 irq_rcv drops after clear");
        rd(8'hC8, 0, "R5 doorbell cleared");

        // R3/R6 acknowledge
        wr(8'h80, 32'h2);
        chk(32'(irq_snd), 1, "R6 ack raises irq_snd");
        chk(32'(irq_rcv), 0, "R7 ack not on irq_rcv");
        rd(8'hC8, 32'h2, "R4 ack in status bit 1");
        wr(8'hC4, 32'h2);
        chk(32'(irq_snd), 0, "R6 irq_snd drops after clear");

        // R3 both at once
        wr(8'h80, 32'hFFFFFFFF);
        rd(8'hC8, 32'h3, "R3 both events one write");
        chk(32'({irq_snd, irq_rcv}), 3, "R6 R7 both irqs");
        wr(8'hC4, 32'h3);
        rd(8'hC8, 0, "R5 both cleared");

        // R6/R7 masked
        wr(8'hBC, 32'h0);
        wr(8'hC0, 32'h0);
        wr(8'h80, 32'h3);
        chk(32'({irq_snd, irq_rcv}), 0, "R6 R7 disabled irqs stay low");
        rd(8'hC8, 32'h3, "R4 status set while masked");
        wr(8'hC0, 32'h2);
        chk(32'(irq_rcv), 1, "R7 enable ack bit on receiver");
        wr(8'hC4, 32'h3);

        // R11 write-only and unmapped offsets
        rd(8'h80, 0, "R11 trigger reads zero");
        rd(8'hC4, 0, "R11 clear reads zero");
        rd(8'h84, 0, "R11 unmapped reads zero");
        rd(8'hFC, 0, "R11 top offset reads zero");
        rd(8'h10, 32'h12345678, "R2 word 4 after traffic");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule